// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Bridge

This block connects a single-cycle request/response port inside a synchronous design to an external asynchronous static RAM. The RAM holds 16-bit words at 19-bit word addresses. A requester presents an address, write data, a per-byte enable mask and a direction, all qualified by a valid signal. The bridge accepts the request when it is idle and stores every field at that moment. It then drives the memory through a fixed sequence of phases whose lengths are set by parameters.

Selecting the memory takes two chip enables of opposite polarity. Each byte lane has its own active-low enable, and that enable gates both reads and writes. The bridge never drives the data bus unless it is writing. After a read it deselects the chip for a cycle before it can accept new work. This keeps the memory's output drivers and the bridge's write drivers from overlapping. A request with no byte enabled finishes at once, without selecting the chip.

Top module: `sram_bridge`

## Requirements
- R1: After reset and between accesses, the memory side is idle: `mem_ce1_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, all of `mem_be_n` high, and `mem_dq_oe`=0. `req_ready` is high in this state and only in this state.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Address, write data, direction and byte mask are captured at that edge, so changing the inputs afterwards has no effect on the access. `req_ready` is low in the cycle after acceptance.
- R3: For a write, the chip is selected with address and byte enables stable for at least SETUP_CNT cycles before `mem_we_n` falls. `mem_we_n` stays low for exactly PULSE_CNT cycles. Selection, address and byte enables are then held for at least HOLD_CNT cycles after `mem_we_n` rises. A write keeps `req_ready` low for SETUP_CNT+PULSE_CNT+HOLD_CNT cycles.
- R4: `req_be[0]` maps to `mem_be_n[0]` (data bits 7:0) and `req_be[1]` maps to `mem_be_n[1]` (bits 15:8). Both are active low on the memory side. A write changes only the enabled bytes.
- R5: `mem_dq_oe` is high only while the chip is selected for a write. It stays high until after `mem_we_n` has risen, and it is never high while `mem_oe_n` is low.
- R6: For a read, the chip is selected with `mem_oe_n` low and `mem_we_n` high for exactly ACCESS_CNT cycles. The bus is then sampled, and the data appears on `rsp_rdata` with a one-cycle `rsp_valid` pulse in the next cycle.
- R7: Read bytes whose enable bit was 0 are returned as zero, whatever the memory bus carries.
- R8: A request with `req_be`=0 completes without selecting the chip or pulsing either strobe. A write of this kind leaves memory unchanged. A read of this kind returns `rsp_rdata`=0 with a `rsp_valid` pulse.
- R9: In the cycle that carries a read's `rsp_valid`, the chip is already deselected and `req_ready` is low. This gives at least one dead cycle before any following access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 0 = low byte, active high |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, disabled bytes zero |
| mem_ce1_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Chip enable, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Byte-lane enables, active low, bit 0 = low byte |
| mem_addr | output | 19 | Memory address |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 16 | Data arriving from memory |

## Verification
The bench sweeps every byte mask over sixteen addresses whose high and low address bits both vary. The memory model puts a fixed junk pattern on disabled lanes and on an undriven bus. A bridge that skipped the lane masking would therefore return that junk instead of zero. A bridge that used the inputs live instead of the captured copy would go wrong, because the bench inverts every request input right after acceptance. A bridge with the strobe counts off by one would fail the cycle-exact checks on pulse width, hold length and response time. Zero-mask requests are mixed in: one that still touched the chip would be caught by the strobe counter, and one that corrupted memory would be caught by the readback.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSETUP = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_RACC   = 3'd4,
    ST_RTURN  = 3'd5,
    ST_NOP    = 3'd6
  } seq_state_e;

  function automatic logic is_write_phase(input seq_state_e s);
    return (s == ST_WSETUP) || (s == ST_WPULSE) || (s == ST_WHOLD);
  endfunction

  function automatic logic is_selected(input seq_state_e s);
    return is_write_phase(s) || (s == ST_RACC);
  endfunction

endpackage

// File: rtl/sram_bridge_timer.sv
module sram_bridge_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

  // R3
  tmr_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_bridge_lane.sv
module sram_bridge_lane #(
  parameter int LANE_W = 8
) (
  input  logic              lane_on,
  input  logic [LANE_W-1:0] bus_byte,
  output logic [LANE_W-1:0] rd_byte
);

  assign rd_byte = lane_on ? bus_byte : '0;

endmodule

// File: rtl/sram_bridge_seq.sv
module sram_bridge_seq
  import sram_bridge_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 16,
  parameter int LANES      = 2,
  parameter int CNT_W      = 4,
  parameter int SETUP_CNT  = 2,
  parameter int PULSE_CNT  = 2,
  parameter int HOLD_CNT   = 1,
  parameter int ACCESS_CNT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  input  logic              tmr_done,
  input  logic [DATA_W-1:0] rd_masked,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  seq_state_e state_q, state_d;

  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;

  logic              take;
  logic [ADDR_W-1:0] addr_nx;
  logic [DATA_W-1:0] wdata_nx;
  logic [LANES-1:0]  be_nx;
  logic              sel_d;
  logic              wph_d;
  logic              rd_finish;
  logic              nop_rd_finish;

  assign take     = (state_q == ST_IDLE) && req_valid;
  assign addr_nx  = take ? req_addr  : addr_q;
  assign wdata_nx = take ? req_wdata : wdata_q;
  assign be_nx    = take ? req_be    : be_q;
  assign sel_d    = is_selected(state_d);
  assign wph_d    = is_write_phase(state_d);
  assign rd_finish     = (state_q == ST_RACC) && tmr_done;
  assign nop_rd_finish = (state_q == ST_NOP) && !wr_q;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_be == '0) begin
            state_d = ST_NOP;
          end else if (req_write) begin
            state_d  = ST_WSETUP;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(SETUP_CNT - 1);
          end else begin
            state_d  = ST_RACC;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(ACCESS_CNT - 1);
          end
        end
      end
      ST_WSETUP: begin
        if (tmr_done) begin
          state_d  = ST_WPULSE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(PULSE_CNT - 1);
        end
      end
      ST_WPULSE: begin
        if (tmr_done) begin
          state_d  = ST_WHOLD;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(HOLD_CNT - 1);
        end
      end
      ST_WHOLD: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      ST_RACC: begin
        if (tmr_done) state_d = ST_RTURN;
      end
      ST_RTURN: state_d = ST_IDLE;
      ST_NOP:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      wr_q       <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      be_q       <= '0;
      req_ready  <= 1'b1;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      mem_ce1_n  <= 1'b1;
      mem_ce2    <= 1'b0;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_be_n   <= '1;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take) begin
        wr_q    <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
      end
      req_ready <= (state_d == ST_IDLE);
      rsp_valid <= rd_finish || nop_rd_finish;
      if (rd_finish) begin
        rsp_rdata <= rd_masked;
      end else if (nop_rd_finish) begin
        rsp_rdata <= '0;
      end
      mem_ce1_n <= !sel_d;
      mem_ce2   <= sel_d;
      mem_we_n  <= (state_d != ST_WPULSE);
      mem_oe_n  <= (state_d != ST_RACC);
      mem_be_n  <= sel_d ? ~be_nx : '1;
      if (sel_d) mem_addr <= addr_nx;
      mem_dq_oe <= wph_d;
      if (wph_d) mem_dq_out <= wdata_nx;
    end
  end

  // R1
  idle_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n &&
                   (&mem_be_n) && !mem_dq_oe));

  // R5
  bus_release_chk: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (mem_oe_n && !mem_ce1_n && mem_ce2));

  // R3
  we_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> ($past(!mem_ce1_n) && $stable(mem_addr) && $stable(mem_be_n)));

  // R3
  we_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (!mem_ce1_n && mem_dq_oe && $stable(mem_addr) && $stable(mem_be_n)));

  // R6
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R9
  read_turn_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (!req_ready && mem_ce1_n));

  // R8
  nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_NOP) |-> (mem_ce1_n && mem_we_n && mem_oe_n));

endmodule

// File: rtl/sram_bridge.sv
module sram_bridge #(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 16,
  parameter int SETUP_CNT  = 2,
  parameter int PULSE_CNT  = 2,
  parameter int HOLD_CNT   = 1,
  parameter int ACCESS_CNT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W/8-1:0] mem_be_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int LANES   = DATA_W / 8;
  localparam int MAX_AB  = (SETUP_CNT > PULSE_CNT) ? SETUP_CNT : PULSE_CNT;
  localparam int MAX_CD  = (HOLD_CNT > ACCESS_CNT) ? HOLD_CNT : ACCESS_CNT;
  localparam int MAX_CNT = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic [DATA_W-1:0] rd_masked;

  sram_bridge_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_bridge_lane #(.LANE_W(8)) u_lane (
      .lane_on  (!mem_be_n[g]),
      .bus_byte (mem_dq_in[g*8 +: 8]),
      .rd_byte  (rd_masked[g*8 +: 8])
    );
  end

  sram_bridge_seq #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .LANES      (LANES),
    .CNT_W      (CNT_W),
    .SETUP_CNT  (SETUP_CNT),
    .PULSE_CNT  (PULSE_CNT),
    .HOLD_CNT   (HOLD_CNT),
    .ACCESS_CNT (ACCESS_CNT)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_be     (req_be),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .tmr_done   (tmr_done),
    .rd_masked  (rd_masked),
    .mem_ce1_n  (mem_ce1_n),
    .mem_ce2    (mem_ce2),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_be_n   (mem_be_n),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );

endmodule

// File: tb/sram_bridge_bench.sv
module sram_bridge_bench;

  localparam int SETUP  = 2;
  localparam int PULSE  = 2;
  localparam int HOLD   = 1;
  localparam int ACCESS = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic rsp_valid;
  logic [15:0] rsp_rdata;
  logic mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [18:0] mem_addr;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in;

  int n_checks = 0;
  int n_fail = 0;

  logic [15:0] mdl [16];
  logic [15:0] refm [16];

  logic [18:0] op_addr = '0;
  int strobe_seen = 0;
  bit bad_bus = 0;
  bit addr_bad = 0;

  always #4 clk = ~clk;

  sram_bridge #(
    .SETUP_CNT(SETUP), .PULSE_CNT(PULSE), .HOLD_CNT(HOLD), .ACCESS_CNT(ACCESS)
  ) u_sram_bridge (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // memory model: junk on disabled lanes and idle bus
  always_comb begin
    if (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n) begin
      mem_dq_in[7:0]  = !mem_be_n[0] ? mdl[mem_addr[3:0]][7:0]  : 8'hA5;
      mem_dq_in[15:8] = !mem_be_n[1] ? mdl[mem_addr[3:0]][15:8] : 8'hA5;
    end else begin
      mem_dq_in = 16'h5A5A;
    end
  end

  always @(posedge mem_we_n) begin
    if (!mem_ce1_n && mem_ce2 && mem_dq_oe) begin
      if (!mem_be_n[0]) mdl[mem_addr[3:0]][7:0]  = mem_dq_out[7:0];
      if (!mem_be_n[1]) mdl[mem_addr[3:0]][15:8] = mem_dq_out[15:8];
    end
  end

  // write-phase timing monitor
  int pre_c = 0, lo_c = 0, post_c = 0;
  bit after_rise = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!mem_ce1_n) strobe_seen++;
      if (!mem_ce1_n && mem_addr != op_addr) addr_bad = 1;
      if ((!mem_oe_n && mem_dq_oe) || (mem_dq_oe && mem_ce1_n)) bad_bus = 1;
      if (mem_ce1_n) begin
        if (after_rise) check(post_c >= HOLD, "R3 hold cycles", post_c, HOLD);
        after_rise = 0; pre_c = 0; lo_c = 0; post_c = 0;
      end else if (!mem_we_n) begin
        if (lo_c == 0) check(pre_c >= SETUP, "R3 setup cycles", pre_c, SETUP);
        lo_c++;
      end else if (lo_c > 0 && !after_rise) begin
        check(lo_c == PULSE, "R3 pulse width", lo_c, PULSE);
        check(mem_dq_oe == 1'b1, "R5 bus held past WE rise", mem_dq_oe, 1);
        after_rise = 1; post_c = 1;
      end else if (after_rise) begin
        post_c++;
      end else begin
        pre_c++;
      end
    end
  end

  task automatic run_op(input logic wr, input logic [18:0] a, input logic [15:0] d,
                        input logic [1:0] be, output logic [15:0] rd);
    int waitc;
    logic [15:0] mask;
    rd = '0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    op_addr = a; strobe_seen = 0; bad_bus = 0; addr_bad = 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0; req_write = ~wr; req_addr = ~a; req_wdata = ~d; req_be = ~be;
    check(req_ready == 1'b0, "R2 ready low after accept", req_ready, 0);
    mask = {{8{be[1]}}, {8{be[0]}}};
    if (wr) begin
      waitc = 1;
      while (!req_ready && waitc < 100) begin @(negedge clk); waitc++; end
      check(waitc - 1 == ((be == 2'b00) ? 1 : SETUP + PULSE + HOLD),
            "R3 write busy cycles", waitc - 1, (be == 2'b00) ? 1 : SETUP + PULSE + HOLD);
      refm[a[3:0]] = (refm[a[3:0]] & ~mask) | (d & mask);
    end else begin
      waitc = 1;
      while (!rsp_valid && waitc < 100) begin @(negedge clk); waitc++; end
      rd = rsp_rdata;
      if (be == 2'b00) begin
        check(rsp_rdata == 16'h0, "R8 empty read data", rsp_rdata, 0);
        check(waitc == 2, "R8 empty read latency", waitc, 2);
      end else begin
        check(rsp_rdata == (refm[a[3:0]] & mask), "R6 R7 read data", rsp_rdata, refm[a[3:0]] & mask);
        check(waitc == ACCESS + 1, "R6 read latency", waitc, ACCESS + 1);
        check(!req_ready && mem_ce1_n && !mem_ce2, "R9 turnaround deselect",
              {req_ready, mem_ce1_n, mem_ce2}, 3'b010);
      end
      @(negedge clk);
      check(rsp_valid == 1'b0, "R6 single pulse", rsp_valid, 0);
    end
    check(!bad_bus, "R5 bus drive window", bad_bus, 0);
    if (be == 2'b00) check(strobe_seen == 0, "R8 no strobe", strobe_seen, 0);
    else check(!addr_bad, "R3 address stable", addr_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic [18:0] a;
    for (int i = 0; i < 16; i++) begin
      mdl[i]  = (16'h1111 * 16'(i)) ^ 16'hC3A0;
      refm[i] = mdl[i];
    end
    repeat (4) @(negedge clk);
    check(req_ready && mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe,
          "R1 idle during reset", {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n}, 4'b1011);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe,
          "R1 idle after reset", {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n}, 4'b1011);

    // R6 R7: read sweep of initial content, all lane masks
    for (int i = 0; i < 16; i++) begin
      a = {4'(i), 11'h2A5, 4'(i)};
      for (int b = 1; b < 4; b++) run_op(1'b0, a, 16'h0, 2'(b), rd);
    end

    // R4: byte-lane writes, then full readback
    for (int i = 0; i < 16; i++) begin
      a = {4'(i), 11'h2A5, 4'(i)};
      for (int b = 1; b < 4; b++)
        run_op(1'b1, a, 16'(i * 16'h0F1D + b * 16'h3303), 2'(b), rd);
    end
    for (int i = 0; i < 16; i++) begin
      a = {4'(i), 11'h2A5, 4'(i)};
      run_op(1'b0, a, 16'h0, 2'b11, rd);
      check(rd == refm[i], "R4 lane write readback", rd, refm[i]);
    end
    // R4: single lane writes leave the other byte intact
    run_op(1'b1, {4'd3, 11'h2A5, 4'd3}, 16'hBEEF, 2'b01, rd);
    run_op(1'b1, {4'd5, 11'h2A5, 4'd5}, 16'hCAFE, 2'b10, rd);
    run_op(1'b0, {4'd3, 11'h2A5, 4'd3}, 16'h0, 2'b11, rd);
    check(rd == refm[3], "R4 low lane only", rd, refm[3]);
    run_op(1'b0, {4'd5, 11'h2A5, 4'd5}, 16'h0, 2'b11, rd);
    check(rd == refm[5], "R4 high lane only", rd, refm[5]);

    // R8: empty-mask requests
    run_op(1'b1, {4'd7, 11'h2A5, 4'd7}, 16'hFFFF, 2'b00, rd);
    run_op(1'b0, {4'd7, 11'h2A5, 4'd7}, 16'h0, 2'b11, rd);
    check(rd == refm[7], "R8 empty write leaves memory", rd, refm[7]);
    run_op(1'b0, {4'd7, 11'h2A5, 4'd7}, 16'h0, 2'b00, rd);
    run_op(1'b0, {4'd8, 11'h2A5, 4'd8}, 16'h0, 2'b00, rd);

    // R9 then R2: read followed directly by write
    run_op(1'b0, {4'd9, 11'h2A5, 4'd9}, 16'h0, 2'b10, rd);
    run_op(1'b1, {4'd9, 11'h2A5, 4'd9}, 16'h1234, 2'b11, rd);
    run_op(1'b0, {4'd9, 11'h2A5, 4'd9}, 16'h0, 2'b11, rd);
    check(rd == 16'h1234, "R2 captured write data", rd, 16'h1234);

    repeat (2) @(negedge clk);
    check(req_ready && mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe,
          "R1 idle at end", {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n}, 4'b1011);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule